// File: doc/BRIEF.md
# Three-Channel Interval Timer Register Interface

This block is the byte-wide host front end that sits in front of three interval counter channels. A 2-bit address selects one of three per-channel data ports (0, 1, 2) or the control port (3). Writes to the control port either program a channel's access width and counting mode, snapshot a channel's count, or issue a multi-channel read-back command that can capture count and status for several channels at once. Writes to a data port are assembled into a 16-bit load value according to the channel's access width. When the value is complete, it is handed to the counting core with a one-cycle strobe.

Reads from a data port return one byte per access. The byte comes from a pending status snapshot if one exists. Failing that, it comes from a pending count snapshot, and otherwise from the live count supplied by the counting core. Each channel tracks its own byte order for reads and writes. A snapshot, once taken, is held until it has been read out; later snapshot requests do not replace it. The counting cores are outside this block: they consume the load strobe, the load value and the mode, and they supply the live count and the output level.

Top module: `tmr_regif`

## Requirements
- R1: A control-port write with bits 7:6 in 0..2 and a nonzero bits 5:4 programs the selected channel: bits 5:4 become its access width (1 low byte only, 2 high byte only, 3 low then high), bits 3:1 its mode, and bit 0 its BCD flag. The mode appears on `chan_mode` from the cycle after the write.
- R2: With access width 1, a data write of byte b pulses that channel's `load_stb` for exactly one cycle, starting the cycle after the write, with `load_val` = {8'h00, b}.
- R3: With access width 2, a data write of byte b pulses the strobe with `load_val` = {b, 8'h00}.
- R4: With access width 3, the first data write only stores its byte and raises no strobe. The second write pulses the strobe with `load_val` = {second, first}.
- R5: Programming a channel (R1) resets both its write and its read byte pointer, so the next word-mode write and the next word-mode read are each taken as the low byte.
- R6: A control-port write with bits 5:4 = 0 latches the selected channel's live count at that write. Mode and access width are unchanged. Later reads return the latched value in the channel's access order: width 1 gives the low byte, width 2 the high byte, and width 3 the low byte then the high byte. The latch clears after its last byte.
- R7: While a count latch or a status latch of a channel is pending, a further request of the same kind leaves the held value unchanged.
- R8: A control-port write with bits 7:6 = 3 is a read-back command. Bit 1, bit 2 and bit 3 select channels 0, 1 and 2. Bit 5 = 0 requests a count latch and bit 4 = 0 requests a status latch for every selected channel. The status byte is {output level, 1'b0, access width[1:0], mode[2:0], BCD}.
- R9: A data read returns a pending status byte first, then pending count bytes, then live count bytes. Reading the status byte does not disturb a pending count latch.
- R10: Without a latch, width 1 reads return the live low byte, width 2 reads the live high byte, and width 3 reads alternate low byte, high byte.
- R11: A read from address 3 returns 8'h00 and changes no channel state.
- R12: After reset, every channel is in access width 3 and mode 3, with no pending latch and both byte pointers at the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Port select: 0..2 channel data, 3 control |
| bus_wr | input | 1 | Write strobe; wins over bus_rd in the same cycle |
| bus_rd | input | 1 | Read strobe; side effects take place at the clock edge |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte for the addressed port (combinational) |
| live_count | input | 48 | Live 16-bit count per channel, channel 0 in the low bits |
| live_out | input | 3 | Output level per channel |
| load_stb | output | 3 | One-cycle load pulse per channel |
| load_val | output | 48 | 16-bit load value per channel |
| chan_mode | output | 9 | 3-bit counting mode per channel |

## Verification
The hardest state to reach is a channel that holds a status snapshot and a count snapshot together. The live count and output level must also move after the capture, so that a stale value can be told apart from a fresh one. The bench reaches this with one read-back command that targets two channels with both latch kinds enabled. It then changes the live inputs, reissues latch requests, and reads each channel byte by byte. The expected order of status, latched bytes and live bytes is queued ahead of every read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_LO   = 2'd1,
        ACC_HI   = 2'd2,
        ACC_WORD = 2'd3
    } acc_e;

    typedef struct packed {
        logic data_wr;
        logic prog;
        logic cnt_latch;
        logic st_latch;
        logic rd;
    } chan_cmd_t;

    typedef struct packed {
        acc_e               acc;
        logic [MODE_W-1:0]  mode;
        logic               bcd;
        logic               wr_hi;
        logic               rd_hi;
        logic [BYTE_W-1:0]  wlat;
        acc_e               cl_st;
        logic [CNT_W-1:0]   cl_val;
        logic               st_pend;
        logic [BYTE_W-1:0]  st_val;
        logic               ld_stb;
        logic [CNT_W-1:0]   ld_val;
    } chan_st_t;

endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
    import tmr_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [1:0]      bus_addr,
    input  logic [6:0]      ctl_hi,
    output chan_cmd_t       cmd [NCH]
);

    localparam logic [1:0] CTL_ADDR = 2'd3;
    localparam logic [1:0] RB_SEL   = 2'd3;

    logic       ctl_wr;
    logic       is_rb;
    logic [1:0] sel;
    logic [1:0] acc;

    always_comb begin
        ctl_wr = bus_wr && (bus_addr == CTL_ADDR);
        sel    = ctl_hi[6:5];
        acc    = ctl_hi[4:3];
        is_rb  = (sel == RB_SEL);
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [1:0] CH = 2'(c);
        always_comb begin
            cmd[c].data_wr   = bus_wr && (bus_addr == CH);
            cmd[c].rd        = bus_rd && !bus_wr && (bus_addr == CH);
            cmd[c].prog      = ctl_wr && !is_rb && (sel == CH) && (acc != 2'd0);
            cmd[c].cnt_latch = ctl_wr && ((!is_rb && (sel == CH) && (acc == 2'd0))
                                         || (is_rb && ctl_hi[c] && !ctl_hi[4]));
            cmd[c].st_latch  = ctl_wr && is_rb && ctl_hi[c] && !ctl_hi[3];
        end
    end

endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
    import tmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  chan_cmd_t          cmd,
    input  logic [BYTE_W-1:0]  wdata,
    input  logic [CNT_W-1:0]   live_count,
    input  logic               live_out,
    output logic [BYTE_W-1:0]  rd_byte,
    output logic               ld_stb,
    output logic [CNT_W-1:0]   ld_val,
    output logic [MODE_W-1:0]  mode
);

    chan_st_t st_d, st_q;

    // Byte presented on a read, by priority: status, latched count, live count
    always_comb begin
        if (st_q.st_pend) begin
            rd_byte = st_q.st_val;
        end else if (st_q.cl_st != ACC_NONE) begin
            rd_byte = (st_q.cl_st == ACC_HI) ? st_q.cl_val[CNT_W-1:BYTE_W]
                                             : st_q.cl_val[BYTE_W-1:0];
        end else begin
            case (st_q.acc)
                ACC_HI:   rd_byte = live_count[CNT_W-1:BYTE_W];
                ACC_WORD: rd_byte = st_q.rd_hi ? live_count[CNT_W-1:BYTE_W]
                                               : live_count[BYTE_W-1:0];
                default:  rd_byte = live_count[BYTE_W-1:0];
            endcase
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.ld_stb = 1'b0;

        if (cmd.prog) begin
            st_d.acc   = acc_e'(wdata[5:4]);
            st_d.mode  = wdata[3:1];
            st_d.bcd   = wdata[0];
            st_d.wr_hi = 1'b0;
            st_d.rd_hi = 1'b0;
        end

        if (cmd.cnt_latch && (st_q.cl_st == ACC_NONE)) begin
            st_d.cl_val = live_count;
            st_d.cl_st  = st_q.acc;
        end

        if (cmd.st_latch && !st_q.st_pend) begin
            st_d.st_val  = {live_out, 1'b0, st_q.acc, st_q.mode, st_q.bcd};
            st_d.st_pend = 1'b1;
        end

        if (cmd.data_wr) begin
            case (st_q.acc)
                ACC_HI: begin
                    st_d.ld_val = {wdata, {BYTE_W{1'b0}}};
                    st_d.ld_stb = 1'b1;
                end
                ACC_WORD: begin
                    if (!st_q.wr_hi) begin
                        st_d.wlat  = wdata;
                        st_d.wr_hi = 1'b1;
                    end else begin
                        st_d.ld_val = {wdata, st_q.wlat};
                        st_d.ld_stb = 1'b1;
                        st_d.wr_hi  = 1'b0;
                    end
                end
                default: begin
                    st_d.ld_val = {{BYTE_W{1'b0}}, wdata};
                    st_d.ld_stb = 1'b1;
                end
            endcase
        end

        if (cmd.rd) begin
            if (st_q.st_pend) begin
                st_d.st_pend = 1'b0;
            end else if (st_q.cl_st != ACC_NONE) begin
                st_d.cl_st = (st_q.cl_st == ACC_WORD) ? ACC_HI : ACC_NONE;
            end else if (st_q.acc == ACC_WORD) begin
                st_d.rd_hi = !st_q.rd_hi;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.acc  <= ACC_WORD;
            st_q.mode <= 3'd3;
        end else begin
            st_q <= st_d;
        end
    end

    assign ld_stb = st_q.ld_stb;
    assign ld_val = st_q.ld_val;
    assign mode   = st_q.mode;

    // R4: the first byte of a word write never loads
    p_word_first_no_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.data_wr && (st_q.acc == ACC_WORD) && !st_q.wr_hi |=> !ld_stb);

    // R5: programming resets both byte pointers
    p_prog_ptr_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.prog |=> !st_q.wr_hi && !st_q.rd_hi);

    // R7: a pending count snapshot holds until it is read
    p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cl_st != ACC_NONE) && !cmd.rd |=> $stable(st_q.cl_val) && (st_q.cl_st != ACC_NONE));

    // R7: a pending status snapshot holds until it is read
    p_status_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.st_pend && !cmd.rd |=> st_q.st_pend && $stable(st_q.st_val));

    // R9: reading the status leaves the count snapshot untouched
    p_status_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.rd && st_q.st_pend |=> !st_q.st_pend && $stable(st_q.cl_st) && $stable(st_q.cl_val));

    // R11: with no command for this channel its state does not move
    p_idle_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd.rd || cmd.data_wr || cmd.prog || cmd.cnt_latch || cmd.st_latch)
        |=> $stable(st_q.acc) && $stable(st_q.mode) && $stable(st_q.rd_hi)
            && $stable(st_q.wr_hi) && $stable(st_q.cl_st) && $stable(st_q.st_pend));

endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             bus_addr,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [BYTE_W-1:0]      bus_wdata,
    output logic [BYTE_W-1:0]      bus_rdata,
    input  logic [NCH*CNT_W-1:0]   live_count,
    input  logic [NCH-1:0]         live_out,
    output logic [NCH-1:0]         load_stb,
    output logic [NCH*CNT_W-1:0]   load_val,
    output logic [NCH*MODE_W-1:0]  chan_mode
);

    chan_cmd_t         cmd     [NCH];
    logic [BYTE_W-1:0] ch_byte [NCH];

    tmr_cmd_decode #(.NCH(NCH)) u_dec (
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .ctl_hi   (bus_wdata[7:1]),
        .cmd      (cmd)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        tmr_chan_port u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmd        (cmd[c]),
            .wdata      (bus_wdata),
            .live_count (live_count[c*CNT_W +: CNT_W]),
            .live_out   (live_out[c]),
            .rd_byte    (ch_byte[c]),
            .ld_stb     (load_stb[c]),
            .ld_val     (load_val[c*CNT_W +: CNT_W]),
            .mode       (chan_mode[c*MODE_W +: MODE_W])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == 2'(c)) bus_rdata = ch_byte[c];
        end
    end

    // R2: at most one channel loads per cycle
    p_one_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_stb));

endmodule

// File: tb/tmr_regif_bench.sv
module tmr_regif_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [47:0] live_count = '0;
    logic [2:0]  live_out = '0;
    logic [2:0]  load_stb;
    logic [47:0] load_val;
    logic [8:0]  chan_mode;

    int n_run  = 0;
    int n_fail = 0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    tmr_regif u_tmr_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .live_count (live_count),
        .live_out   (live_out),
        .load_stb   (load_stb),
        .load_val   (load_val),
        .chan_mode  (chan_mode)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: every read cycle pops one expected byte
    always @(negedge clk) begin
        if (rst_n && bus_rd) begin
            if (exp_q.size() == 0) begin
                chk(32'(bus_rdata), 32'hFFFF_FFFF, "unexpected read");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(32'(bus_rdata), 32'(e.val), e.tag);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        @(posedge clk); #1;
        exp_q.push_back('{val: e, tag: tag});
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    // Data write followed by a check of the strobe and value in the pulse cycle
    task automatic wr_load(input int ch, input logic [7:0] d, input logic exp_stb,
                           input logic [15:0] exp_val, input string tag);
        wr(2'(ch), d);
        @(negedge clk);
        chk(32'(load_stb), exp_stb ? (32'd1 << ch) : 32'd0, tag);
        if (exp_stb) chk(32'(load_val[ch*16 +: 16]), 32'(exp_val), tag);
    endtask

    initial begin
        live_count = {16'h0F0E, 16'hABCD, 16'h1234};
        live_out   = 3'b101;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(32'(chan_mode), {23'd0, 3'd3, 3'd3, 3'd3}, "R12 modes");
        chk(32'(load_stb), 32'd0, "R12 no strobe");
        rd(2'd0, 8'h34, "R12 word low");
        rd(2'd0, 8'h12, "R12 word high");

        // R4: word write
        wr_load(0, 8'h78, 1'b0, 16'h0, "R4 first byte no load");
        wr_load(0, 8'h56, 1'b1, 16'h5678, "R4 word load");

        // R1 / R2: channel 1 low-only, mode 2
        wr(2'd3, 8'h54);
        @(negedge clk);
        chk(32'(chan_mode[5:3]), 32'd2, "R1 mode ch1");
        wr_load(1, 8'h9A, 1'b1, 16'h009A, "R2 low load");
        rd(2'd1, 8'hCD, "R10 low only");
        rd(2'd1, 8'hCD, "R10 low only again");

        // R3: channel 2 high-only, mode 0
        wr(2'd3, 8'hA0);
        wr_load(2, 8'h33, 1'b1, 16'h3300, "R3 high load");
        rd(2'd2, 8'h0F, "R10 high only");
        rd(2'd2, 8'h0F, "R10 high only again");

        // R5: pointers reset by programming
        wr_load(0, 8'h11, 1'b0, 16'h0, "R5 pending low byte");
        rd(2'd0, 8'h34, "R5 read low");
        wr(2'd3, 8'h36);
        wr_load(0, 8'h22, 1'b0, 16'h0, "R5 write pointer reset");
        wr_load(0, 8'h44, 1'b1, 16'h4422, "R5 word after reprogram");
        rd(2'd0, 8'h34, "R5 read pointer reset");
        rd(2'd0, 8'h12, "R10 word alternates");

        // R6 / R7: count latch and latch-once
        wr(2'd3, 8'h00);
        live_count[15:0] = 16'h5555;
        wr(2'd3, 8'h00);
        @(negedge clk);
        chk(32'(chan_mode[2:0]), 32'd3, "R6 mode unchanged");
        rd(2'd0, 8'h34, "R7 latched low kept");
        rd(2'd0, 8'h12, "R6 latched high");
        rd(2'd0, 8'h55, "R6 latch cleared, live low");
        rd(2'd0, 8'h55, "R10 live high");

        // R8 / R9: read-back of channels 1 and 2, count and status
        wr(2'd3, 8'hCC);
        live_count[31:16] = 16'h7777;
        live_count[47:32] = 16'h2222;
        live_out = 3'b000;
        rd(2'd1, 8'h14, "R8 status ch1");
        rd(2'd1, 8'hCD, "R9 latched count after status ch1");
        rd(2'd1, 8'h77, "R9 live after latches ch1");
        rd(2'd2, 8'hA0, "R8 status ch2");
        rd(2'd2, 8'h0F, "R9 latched high ch2");
        rd(2'd2, 8'h22, "R9 live ch2");

        // R7 / R8: status-only read-back twice on channel 0
        live_out = 3'b001;
        wr(2'd3, 8'hE2);
        live_out = 3'b000;
        wr(2'd3, 8'hE2);
        rd(2'd0, 8'hB6, "R7 status kept");
        rd(2'd0, 8'h55, "R8 status only, no count latch");

        // R11: address 3 read has no effect
        rd(2'd3, 8'h00, "R11 control read zero");
        live_count[15:0] = 16'hA1B2;
        rd(2'd0, 8'hA1, "R11 pointer kept");

        // R1 / R8: BCD flag and mode 5 in status
        wr(2'd3, 8'h9B);
        @(negedge clk);
        chk(32'(chan_mode[8:6]), 32'd5, "R1 mode ch2");
        live_out = 3'b100;
        wr(2'd3, 8'hE8);
        rd(2'd2, 8'h9B, "R8 status with BCD");

        repeat (2) @(posedge clk);
        chk(32'(exp_q.size()), 32'd0, "scoreboard drained");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule